// File: doc/BRIEF.md
# Addressable JTAG Slot Selection Controller

This block lets one tester-driven JTAG bus reach many bridge devices that share a backplane. Each device runs its own 16-state TAP controller from the common TCK, TMS and TDI lines. A device that is waiting for an address treats its instruction register as an address register. The value shifted in during Shift-IR is compared with the six slot-identification pins when the TAP passes through Update-IR.

A match puts the device into the selected state, where it decodes instructions and drives TDO. A multicast address instead picks every device whose 2-bit group register holds the encoded group. Those devices act on instructions but never drive TDO, so several of them can be written together without contention. Devices that do not match stay deaf until the wait instruction returns them to address decoding.

The two selection flags and the TDO enable are meant to gate the bridge's TDO driver and its own instruction decoder.

Top module: `jtag_slot_select`

## Requirements
- R1: Five consecutive TCK rising edges with TMS high bring the TAP to Test-Logic-Reset; that state, or trstN low, forces the waiting state, clears the group register to 2'b00 and holds selected, mcastSel and tdoEn low.
- R2: On Capture-IR the 8-bit instruction register loads slotId into bits 7:2 and 2'b01 into bits 1:0; Shift-IR moves it out on TDO least significant bit first.
- R3: While waiting, an Update-IR value with bits 7:6 equal to 2'b00 and bits 5:0 equal to slotId enters the selected state (selected=1, mcastSel=0).
- R4: While waiting, any other non-multicast Update-IR value enters the unselected state (both flags 0).
- R5: While waiting, an Update-IR value whose bits 7:2 are 6'b001111 is a multicast address: it enters the multicast state (mcastSel=1, selected=0) when bits 1:0 equal the group register, and the unselected state otherwise; this decode takes precedence over the slot comparison.
- R6: Updating instruction 8'h03 from the selected, unselected or multicast state returns the device to waiting, so the next instruction scan is an address.
- R7: In the selected or multicast state, instruction 8'h05 places the 2-bit group register in the data path: Capture-DR loads the group value, Shift-DR shifts it least significant bit first, and Update-DR writes the shifted value to the group register.
- R8: In the unselected state every instruction other than 8'h03 is ignored: a matching slot address does not select the device and a group write scan leaves the group register unchanged.
- R9: tdoEn is high only in the selected state during Shift-IR or Shift-DR; the waiting, unselected and multicast states keep it low.
- R10: tdo and tdoEn change only on the falling edge of TCK; instructions other than 8'h05 select a 1-bit bypass register that captures 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trstN | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial test data in |
| slotId | input | 6 | Slot identification pins |
| tdo | output | 1 | Serial test data out, valid when tdoEn is high |
| tdoEn | output | 1 | TDO driver enable |
| selected | output | 1 | Device individually selected |
| mcastSel | output | 1 | Device selected as part of a multicast group |

## Verification
The bench sweeps all 64 slot pin values against a matching address, an address with nonzero upper bits and an address with one slot bit flipped, and for each of the four group values it decodes all 256 addresses. A design that compared only six address bits would select on the nonzero-upper-bits address, and one that checked the slot before the multicast prefix would pick slots 60 to 63 individually. Separate cases show that an unselected device ignores a matching address and a group write, that a multicast device writes its group register without driving TDO, and that Test-Logic-Reset clears the group. A design that drove TDO on the rising edge would show the next bit one half-cycle early, and the bench samples just after the rising edge to catch that.

// File: rtl/jtag_slot_select_pkg.sv
package jtag_slot_select_pkg;

  typedef enum logic [3:0] {
    TAP_RESET, TAP_IDLE,
    TAP_SEL_DR, TAP_CAP_DR, TAP_SH_DR, TAP_EX1_DR, TAP_PAU_DR, TAP_EX2_DR, TAP_UPD_DR,
    TAP_SEL_IR, TAP_CAP_IR, TAP_SH_IR, TAP_EX1_IR, TAP_PAU_IR, TAP_EX2_IR, TAP_UPD_IR
  } tapState_e;

  typedef enum logic [1:0] {
    SEL_WAIT, SEL_ON, SEL_OFF, SEL_GROUP
  } selState_e;

  typedef struct packed {
    logic captureIr;
    logic shiftIr;
    logic captureDr;
    logic shiftDr;
    logic useGroup;
    logic loadGroup;
    logic clearGroup;
    logic driveTdo;
    logic pickDr;
  } dpStrobe_t;

endpackage

// File: rtl/jtag_slot_select_tap.sv
module jtag_slot_select_tap
  import jtag_slot_select_pkg::*;
(
  input  logic      tck,
  input  logic      trstN,
  input  logic      tms,
  output tapState_e tapState
);

  tapState_e nextState;

  always_comb begin
    unique case (tapState)
      TAP_RESET:  nextState = tms ? TAP_RESET  : TAP_IDLE;
      TAP_IDLE:   nextState = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_DR: nextState = tms ? TAP_SEL_IR : TAP_CAP_DR;
      TAP_CAP_DR: nextState = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_SH_DR:  nextState = tms ? TAP_EX1_DR : TAP_SH_DR;
      TAP_EX1_DR: nextState = tms ? TAP_UPD_DR : TAP_PAU_DR;
      TAP_PAU_DR: nextState = tms ? TAP_EX2_DR : TAP_PAU_DR;
      TAP_EX2_DR: nextState = tms ? TAP_UPD_DR : TAP_SH_DR;
      TAP_UPD_DR: nextState = tms ? TAP_SEL_DR : TAP_IDLE;
      TAP_SEL_IR: nextState = tms ? TAP_RESET  : TAP_CAP_IR;
      TAP_CAP_IR: nextState = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_SH_IR:  nextState = tms ? TAP_EX1_IR : TAP_SH_IR;
      TAP_EX1_IR: nextState = tms ? TAP_UPD_IR : TAP_PAU_IR;
      TAP_PAU_IR: nextState = tms ? TAP_EX2_IR : TAP_PAU_IR;
      TAP_EX2_IR: nextState = tms ? TAP_UPD_IR : TAP_SH_IR;
      TAP_UPD_IR: nextState = tms ? TAP_SEL_DR : TAP_IDLE;
      default:    nextState = TAP_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) tapState <= TAP_RESET;
    else        tapState <= nextState;
  end

  // R1: TMS held high keeps the controller parked in Test-Logic-Reset
  p_reset_park_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_RESET && tms) |=> (tapState == TAP_RESET));

endmodule

// File: rtl/jtag_slot_select_ctrl.sv
module jtag_slot_select_ctrl
  import jtag_slot_select_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int GRP_W  = 2,
  parameter int SLOT_W = IR_W - 2,
  parameter logic [IR_W-GRP_W-1:0] MCAST_PREFIX   = 6'b001111,
  parameter logic [IR_W-1:0]       GO_WAIT_CODE   = 8'h03,
  parameter logic [IR_W-1:0]       GROUP_SEL_CODE = 8'h05
) (
  input  logic              tck,
  input  logic              trstN,
  input  tapState_e         tapState,
  input  logic [IR_W-1:0]   irShift,
  input  logic [SLOT_W-1:0] slotId,
  input  logic [GRP_W-1:0]  groupReg,
  output dpStrobe_t         strb,
  output selState_e         selState,
  output logic              selected,
  output logic              mcastSel
);

  localparam logic [IR_W-1:0] BYPASS_CODE = '1;

  logic [IR_W-1:0] instr;
  logic            active;

  function automatic selState_e decodeAddr(input logic [IR_W-1:0] addr,
                                           input logic [SLOT_W-1:0] slot,
                                           input logic [GRP_W-1:0] grp);
    if (addr[IR_W-1:GRP_W] == MCAST_PREFIX)
      return (addr[GRP_W-1:0] == grp) ? SEL_GROUP : SEL_OFF;
    if (addr[IR_W-1:SLOT_W] == '0 && addr[SLOT_W-1:0] == slot)
      return SEL_ON;
    return SEL_OFF;
  endfunction

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      selState <= SEL_WAIT;
      instr    <= BYPASS_CODE;
    end else if (tapState == TAP_RESET) begin
      selState <= SEL_WAIT;
      instr    <= BYPASS_CODE;
    end else if (tapState == TAP_UPD_IR) begin
      unique case (selState)
        SEL_WAIT: begin
          selState <= decodeAddr(irShift, slotId, groupReg);
          instr    <= BYPASS_CODE;
        end
        SEL_ON, SEL_GROUP: begin
          if (irShift == GO_WAIT_CODE) begin
            selState <= SEL_WAIT;
            instr    <= BYPASS_CODE;
          end else begin
            instr    <= irShift;
          end
        end
        SEL_OFF: begin
          if (irShift == GO_WAIT_CODE) selState <= SEL_WAIT;
        end
        default: selState <= SEL_WAIT;
      endcase
    end
  end

  assign active   = (selState == SEL_ON) || (selState == SEL_GROUP);
  assign selected = (selState == SEL_ON);
  assign mcastSel = (selState == SEL_GROUP);

  always_comb begin
    strb            = '0;
    strb.captureIr  = (tapState == TAP_CAP_IR);
    strb.shiftIr    = (tapState == TAP_SH_IR);
    strb.captureDr  = (tapState == TAP_CAP_DR);
    strb.shiftDr    = (tapState == TAP_SH_DR);
    strb.useGroup   = active && (instr == GROUP_SEL_CODE);
    strb.loadGroup  = strb.useGroup && (tapState == TAP_UPD_DR);
    strb.clearGroup = (tapState == TAP_RESET);
    strb.driveTdo   = selected && (strb.shiftIr || strb.shiftDr);
    strb.pickDr     = strb.shiftDr;
  end

  // R1: Test-Logic-Reset always lands in the waiting state
  p_reset_wait_r1: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_RESET) |=> (selState == SEL_WAIT));

  // R4: never both flags at once
  p_flags_excl_r4: assert property (@(posedge tck) disable iff (!trstN)
    $onehot0({selected, mcastSel}));

  // R6: the wait instruction from any addressed state returns to waiting
  p_go_wait_r6: assert property (@(posedge tck) disable iff (!trstN)
    (tapState == TAP_UPD_IR && selState != SEL_WAIT && irShift == GO_WAIT_CODE)
      |=> (selState == SEL_WAIT));

  // R8: an unselected device leaves only through the wait instruction or reset
  p_unsel_stays_r8: assert property (@(posedge tck) disable iff (!trstN)
    (selState == SEL_OFF && tapState != TAP_RESET &&
     !(tapState == TAP_UPD_IR && irShift == GO_WAIT_CODE))
      |=> (selState == SEL_OFF));

endmodule

// File: rtl/jtag_slot_select_dp.sv
module jtag_slot_select_dp
  import jtag_slot_select_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int GRP_W  = 2,
  parameter int SLOT_W = IR_W - 2
) (
  input  logic              tck,
  input  logic              trstN,
  input  dpStrobe_t         strb,
  input  logic              tdi,
  input  logic [SLOT_W-1:0] slotId,
  output logic [IR_W-1:0]   irShift,
  output logic [GRP_W-1:0]  groupReg,
  output logic              tdo,
  output logic              tdoEn
);

  localparam int               FIX_W       = IR_W - SLOT_W;
  localparam logic [FIX_W-1:0] CAPTURE_LOW = FIX_W'(1);

  logic [GRP_W-1:0] drShift;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      irShift <= '0;
    end else if (strb.captureIr) begin
      irShift <= {slotId, CAPTURE_LOW};
    end else if (strb.shiftIr) begin
      irShift <= {tdi, irShift[IR_W-1:1]};
    end
  end

  generate
    if (GRP_W > 1) begin : g_wide_dr
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN) begin
          drShift <= '0;
        end else if (strb.captureDr) begin
          drShift <= strb.useGroup ? groupReg : '0;
        end else if (strb.shiftDr) begin
          drShift <= strb.useGroup ? {tdi, drShift[GRP_W-1:1]}
                                   : {{(GRP_W-1){1'b0}}, tdi};
        end
      end
    end else begin : g_narrow_dr
      always_ff @(posedge tck or negedge trstN) begin
        if (!trstN) begin
          drShift <= '0;
        end else if (strb.captureDr) begin
          drShift <= strb.useGroup ? groupReg : '0;
        end else if (strb.shiftDr) begin
          drShift <= tdi;
        end
      end
    end
  endgenerate

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) begin
      groupReg <= '0;
    end else if (strb.clearGroup) begin
      groupReg <= '0;
    end else if (strb.loadGroup) begin
      groupReg <= drShift;
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b1;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= strb.pickDr ? drShift[0] : irShift[0];
      tdoEn <= strb.driveTdo;
    end
  end

  // R2: capture loads the slot pins above the fixed low pattern
  p_capture_r2: assert property (@(posedge tck) disable iff (!trstN)
    strb.captureIr |=> (irShift == {$past(slotId), CAPTURE_LOW}));

  // R1: reset state of the TAP clears the group register
  p_group_clear_r1: assert property (@(posedge tck) disable iff (!trstN)
    strb.clearGroup |=> (groupReg == '0));

endmodule

// File: rtl/jtag_slot_select.sv
module jtag_slot_select
  import jtag_slot_select_pkg::*;
#(
  parameter int IR_W   = 8,
  parameter int GRP_W  = 2,
  parameter int SLOT_W = IR_W - 2
) (
  input  logic              tck,
  input  logic              trstN,
  input  logic              tms,
  input  logic              tdi,
  input  logic [SLOT_W-1:0] slotId,
  output logic              tdo,
  output logic              tdoEn,
  output logic              selected,
  output logic              mcastSel
);

  tapState_e        tapState;
  selState_e        selState;
  dpStrobe_t        strb;
  logic [IR_W-1:0]  irShift;
  logic [GRP_W-1:0] groupReg;

  jtag_slot_select_tap u_tap (
    .tck      (tck),
    .trstN    (trstN),
    .tms      (tms),
    .tapState (tapState)
  );

  jtag_slot_select_ctrl #(
    .IR_W   (IR_W),
    .GRP_W  (GRP_W),
    .SLOT_W (SLOT_W)
  ) u_ctrl (
    .tck      (tck),
    .trstN    (trstN),
    .tapState (tapState),
    .irShift  (irShift),
    .slotId   (slotId),
    .groupReg (groupReg),
    .strb     (strb),
    .selState (selState),
    .selected (selected),
    .mcastSel (mcastSel)
  );

  jtag_slot_select_dp #(
    .IR_W   (IR_W),
    .GRP_W  (GRP_W),
    .SLOT_W (SLOT_W)
  ) u_dp (
    .tck      (tck),
    .trstN    (trstN),
    .strb     (strb),
    .tdi      (tdi),
    .slotId   (slotId),
    .irShift  (irShift),
    .groupReg (groupReg),
    .tdo      (tdo),
    .tdoEn    (tdoEn)
  );

  // R9: only an individually selected device may drive the bus
  p_tdo_owner_r9: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> selected);

  // R8: an unselected device never changes its group register
  p_unsel_group_r8: assert property (@(posedge tck) disable iff (!trstN)
    (selState == SEL_OFF && tapState != TAP_RESET) |=> $stable(groupReg));

endmodule

// File: tb/jtag_slot_select_bench.sv
`timescale 1ns/1ps
module jtag_slot_select_bench;

  localparam logic [7:0] GO_WAIT   = 8'h03;
  localparam logic [7:0] GROUP_SEL = 8'h05;

  logic       tck = 1'b0;
  logic       trstN = 1'b0;
  logic       tms = 1'b1;
  logic       tdi = 1'b0;
  logic [5:0] slotId = '0;
  logic       tdo, tdoEn, selected, mcastSel;

  int  total = 0;
  int  bad = 0;
  bit  done = 0;
  logic lastTdo, lastEn;

  always #4 tck = ~tck;

  jtag_slot_select u_jtag_slot_select (
    .tck(tck), .trstN(trstN), .tms(tms), .tdi(tdi), .slotId(slotId),
    .tdo(tdo), .tdoEn(tdoEn), .selected(selected), .mcastSel(mcastSel)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // returns {mcastSel, selected} expected after an address update
  function automatic logic [1:0] expFlags(input logic [7:0] a, input logic [5:0] s,
                                          input logic [1:0] g);
    if (a[7:2] == 6'b001111) return (a[1:0] == g) ? 2'b10 : 2'b00;
    if (a[7:6] == 2'b00 && a[5:0] == s) return 2'b01;
    return 2'b00;
  endfunction

  task automatic tick(input logic t, input logic d);
    @(negedge tck); #1;
    lastTdo = tdo;
    lastEn  = tdoEn;
    tms = t;
    tdi = d;
  endtask

  task automatic settle();
    @(negedge tck); #1;
  endtask

  task automatic scanIr(input logic [7:0] din, output logic [7:0] dout, output logic enSeen);
    enSeen = 1'b0;
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 8; i++) begin
      tick(i == 7, din[i]);
      dout[i] = lastTdo;
      enSeen |= lastEn;
    end
    tick(1, 0); tick(0, 0);
    settle();
  endtask

  task automatic scanDr(input logic [1:0] din, output logic [1:0] dout, output logic enSeen);
    enSeen = 1'b0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    for (int i = 0; i < 2; i++) begin
      tick(i == 1, din[i]);
      dout[i] = lastTdo;
      enSeen |= lastEn;
    end
    tick(1, 0); tick(0, 0);
    settle();
  endtask

  task automatic goReset();
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    settle();
  endtask

  initial begin
    logic [7:0] o8;
    logic [1:0] o2;
    logic       en;
    logic [7:0] a;
    logic [1:0] prevG;

    repeat (3) @(negedge tck);
    #1;
    check("R1 reset flags", {30'd0, mcastSel, selected}, 32'd0);
    check("R1 reset tdoEn", {31'd0, tdoEn}, 32'd0);
    @(negedge tck); trstN = 1'b1;
    tick(0, 0);

    // slot sweep: matching, upper-bit and flipped-bit addresses
    for (int s = 0; s < 64; s++) begin
      slotId = 6'(s);
      goReset();
      scanIr({2'b00, 6'(s)}, o8, en);
      check($sformatf("R3/R5 match s=%0d", s), {30'd0, mcastSel, selected},
            {30'd0, expFlags({2'b00, 6'(s)}, 6'(s), 2'b00)});
      scanIr(GO_WAIT, o8, en);
      if (expFlags({2'b00, 6'(s)}, 6'(s), 2'b00) == 2'b01) begin
        check($sformatf("R2 capture s=%0d", s), {24'd0, o8}, {24'd0, 6'(s), 2'b01});
        check($sformatf("R9 drive s=%0d", s), {31'd0, en}, 32'd1);
      end else begin
        check($sformatf("R9 quiet s=%0d", s), {31'd0, en}, 32'd0);
      end
      check($sformatf("R6 wait s=%0d", s), {30'd0, mcastSel, selected}, 32'd0);
      scanIr({2'b10, 6'(s)}, o8, en);
      check($sformatf("R4 upper s=%0d", s), {30'd0, mcastSel, selected}, 32'd0);
      scanIr(GO_WAIT, o8, en);
      a = {2'b00, 6'(s) ^ 6'h20};
      scanIr(a, o8, en);
      check($sformatf("R4 flip s=%0d", s), {30'd0, mcastSel, selected},
            {30'd0, expFlags(a, 6'(s), 2'b00)});
      scanIr(GO_WAIT, o8, en);
    end

    // full address sweep for every group value
    slotId = 6'd5;
    goReset();
    prevG = 2'b00;
    for (int g = 0; g < 4; g++) begin
      scanIr(8'h05, o8, en);
      check($sformatf("R3 select g=%0d", g), {30'd0, mcastSel, selected}, 32'd1);
      scanIr(GROUP_SEL, o8, en);
      scanDr(2'(g), o2, en);
      check($sformatf("R7 capture old g=%0d", g), {30'd0, o2}, {30'd0, prevG});
      scanDr(2'(g), o2, en);
      check($sformatf("R7 capture new g=%0d", g), {30'd0, o2}, 32'(g));
      prevG = 2'(g);
      scanIr(GO_WAIT, o8, en);
      for (int ai = 0; ai < 256; ai++) begin
        a = 8'(ai);
        scanIr(a, o8, en);
        check($sformatf("R3/R4/R5 a=%0h g=%0d", a, g), {30'd0, mcastSel, selected},
              {30'd0, expFlags(a, 6'd5, 2'(g))});
        scanIr(GO_WAIT, o8, en);
        check($sformatf("R9 en a=%0h g=%0d", a, g), {31'd0, en},
              {31'd0, expFlags(a, 6'd5, 2'(g)) == 2'b01});
      end
    end

    // unselected device ignores instructions (group is 3 here)
    scanIr(8'h80, o8, en);
    scanIr(GROUP_SEL, o8, en);
    scanDr(2'b00, o2, en);
    scanIr(8'h05, o8, en);
    check("R8 address ignored", {30'd0, mcastSel, selected}, 32'd0);
    scanIr(GO_WAIT, o8, en);
    scanIr(8'h05, o8, en);
    scanIr(GROUP_SEL, o8, en);
    scanDr(2'b11, o2, en);
    check("R8 group kept", {30'd0, o2}, 32'd3);
    scanIr(GO_WAIT, o8, en);

    // multicast devices act on instructions without driving TDO
    scanIr(8'h3F, o8, en);
    check("R5 mcast g3", {30'd0, mcastSel, selected}, 32'd2);
    scanIr(GROUP_SEL, o8, en);
    check("R9 mcast IR quiet", {31'd0, en}, 32'd0);
    scanDr(2'b10, o2, en);
    check("R9 mcast DR quiet", {31'd0, en}, 32'd0);
    scanIr(GO_WAIT, o8, en);
    scanIr(8'h3E, o8, en);
    check("R7 mcast write", {30'd0, mcastSel, selected}, 32'd2);
    scanIr(GO_WAIT, o8, en);

    // Test-Logic-Reset clears the group and the selection
    goReset();
    scanIr(8'h3C, o8, en);
    check("R1 group cleared", {30'd0, mcastSel, selected}, 32'd2);
    goReset();
    check("R1 tlr drops mcast", {30'd0, mcastSel, selected}, 32'd0);

    // bypass register captures 0 and delays by one bit
    scanIr(8'h05, o8, en);
    scanIr(8'hFF, o8, en);
    scanDr(2'b01, o2, en);
    check("R10 bypass", {30'd0, o2}, 32'd2);

    // TDO changes on the falling edge only (capture = 0001_0101)
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    @(negedge tck); #1;
    check("R10 first bit", {31'd0, tdo}, 32'd1);
    @(posedge tck); #1;
    check("R10 held past rise", {31'd0, tdo}, 32'd1);
    @(negedge tck); #1;
    check("R10 next bit at fall", {31'd0, tdo}, 32'd0);
    tick(1, 0); tick(1, 0); tick(0, 0);
    settle();
    check("R3 still selected", {30'd0, mcastSel, selected}, 32'd1);

    // asynchronous reset
    trstN = 1'b0;
    #1;
    check("R1 trst flags", {30'd0, mcastSel, selected}, 32'd0);
    check("R1 trst tdoEn", {31'd0, tdoEn}, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge tck);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule